// File: doc/BRIEF.md
# Averaging Touch-Coordinate FIFO with Threshold Interrupt

This block sits behind a touch-panel scan sequencer. Each sample-valid strobe delivers one raw 12-bit X and one raw 12-bit Y conversion result. The block adds up a programmable power-of-two number of samples per axis. At the end of each window it pushes the mean pair into a 32-entry FIFO, then starts the next window from zero.

Software drains the FIFO through a small register port. Each data read pops one packed 32-bit word. An empty FIFO answers with an all-ones marker. A status register gathers three conditions: a pen-event flag, a FIFO-level flag that compares the entry count against a programmable threshold, and a sticky overflow flag. Status bits are cleared by writing ones. A mask register selects which flags may drive the registered interrupt line.

Register select (reg_addr): 0 is FIFO data (a read pops), 1 is status (write-one-to-clear), 2 is mask, 3 reads as zero. Status and mask layout: bit 0 is the pen event, bit 2 is the FIFO level, bit 3 is overflow, bit 1 is always zero.

Top module: `coord_avg_fifo`

## Requirements
- R1: With averaging code c (0..8), one pair is pushed on the strobe that completes 2^c accepted samples. Each coordinate equals floor(sum of the window / 2^c). No entry appears before the window completes.
- R2: An averaging code above 8 behaves exactly like code 8 (256-sample windows).
- R3: A FIFO read returns Y in bits 31:20 and X in bits 15:4. Bits 19:16 and 3:0 are zero.
- R4: A data read while the FIFO is empty returns 0xFFFFFFFF and removes nothing.
- R5: A pair completed while the FIFO holds 32 entries and no pop occurs is discarded. Status bit 3 then sets and stays set until a 1 is written to it.
- R6: A pair completed in the same cycle as a data read of a full FIFO is stored. No overflow is flagged and the count stays at 32.
- R7: Status bit 2 sets whenever the entry count is at or above the threshold (0..31). A clear while the count is still there leaves it set. It stays set after the count drops, until it is cleared.
- R8: A pen-event strobe sets status bit 0. Writing 1 to bit 0 clears it. A strobe in the same cycle as the clear wins.
- R9: Only mask bits 0 and 2 are writable. The interrupt output is high one cycle after any status bit is set whose mask bit is also set, and low otherwise.
- R10: After reset the status and mask read zero, the interrupt is low, read data is zero and the FIFO is empty.
- R11: Each window starts from a zero sum, so consecutive windows are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Raw sample strobe |
| smp_x | input | 12 | Raw X conversion |
| smp_y | input | 12 | Raw Y conversion |
| avg_code | input | 4 | Averaging code, 2^code samples per push |
| fifo_thresh | input | 5 | FIFO level threshold |
| pen_evt | input | 1 | Pen up/down event strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 4 | Write data (status/mask bits) |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt line |

## Verification
Two pairs of events can land on the same clock edge. The first is a completed push meeting a data read while the FIFO is full. The bench fills the FIFO to 32 entries, then raises the sample strobe and the data read together. It then checks three things: the popped word is the oldest entry, no overflow flag appears, and the next 32 reads return the remaining entries plus the new one in order. The second pair is a pen strobe meeting a write-one-to-clear of the same bit. It is provoked on one edge and judged by reading status bit 0 back as still set.

// File: rtl/coord_fifo_pkg.sv
package coord_fifo_pkg;

    localparam int COORD_W  = 12;
    localparam int ACC_W    = 20;
    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 8;
    localparam int WORD_W   = 32;
    localparam int STS_W    = 4;

    localparam int ST_PEN  = 0;
    localparam int ST_FIFO = 2;
    localparam int ST_OVF  = 3;

    localparam logic [STS_W-1:0] MASK_WRITABLE = 4'b0101;
    localparam logic [WORD_W-1:0] EMPTY_WORD  = '1;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } coord_pair_t;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c);
        return (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input coord_pair_t p);
        return {p.y, 4'b0000, p.x, 4'b0000};
    endfunction

endpackage

// File: rtl/axis_averager.sv
module axis_averager #(
    parameter int COORD_W = 12,
    parameter int ACC_W   = 20,
    parameter int CODE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [COORD_W-1:0] sample,
    input  logic [CODE_W-1:0]  code,
    output logic               push,
    output logic [COORD_W-1:0] avg
);
    localparam int CNT_W = ACC_W - COORD_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] shifted;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        last_idx = (CNT_W'(1) << code) - CNT_W'(1);
        sum      = acc + {{(ACC_W-COORD_W){1'b0}}, sample};
        shifted  = sum >> code;
        avg      = shifted[COORD_W-1:0];
        push     = valid && (cnt >= last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else if (valid) begin
            if (push) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= sum;
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
        push |=> (acc == '0) && (cnt == '0)); // R11

endmodule

// File: rtl/pair_fifo.sv
module pair_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       drop
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              full;
    logic              do_pop;
    logic              do_push;

    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        drop    = push && !do_push;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH))); // R5
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (full && push && pop) |=> (count == CNT_W'(DEPTH))); // R6
    AST_EMPTY_NOPOP: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty); // R4

endmodule

// File: rtl/irq_status.sv
module irq_status
    import coord_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pen_evt,
    input  logic             level_hit,
    input  logic             drop,
    input  logic             wr_status,
    input  logic             wr_mask,
    input  logic [STS_W-1:0] wdata,
    output logic [STS_W-1:0] status,
    output logic [STS_W-1:0] mask,
    output logic             irq
);
    logic [STS_W-1:0] clr;

    always_comb clr = wr_status ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
            irq    <= 1'b0;
        end else begin
            status[ST_PEN]  <= pen_evt   | (status[ST_PEN]  & ~clr[ST_PEN]);
            status[1]       <= 1'b0;
            status[ST_FIFO] <= level_hit | (status[ST_FIFO] & ~clr[ST_FIFO]);
            status[ST_OVF]  <= drop      | (status[ST_OVF]  & ~clr[ST_OVF]);
            if (wr_mask) mask <= wdata & MASK_WRITABLE;
            irq <= |(status & mask);
        end
    end

    AST_PEN_SET: assert property (@(posedge clk) disable iff (rst)
        pen_evt |=> status[ST_PEN]); // R8
    AST_LEVEL_REASSERT: assert property (@(posedge clk) disable iff (rst)
        level_hit |=> status[ST_FIFO]); // R7
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
        drop |=> status[ST_OVF]); // R5
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |=> !irq); // R9

endmodule

// File: rtl/coord_avg_fifo.sv
module coord_avg_fifo
    import coord_fifo_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic [COORD_W-1:0]        smp_x,
    input  logic [COORD_W-1:0]        smp_y,
    input  logic [CODE_W-1:0]         avg_code,
    input  logic [$clog2(DEPTH)-1:0]  fifo_thresh,
    input  logic                      pen_evt,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [1:0]                reg_addr,
    input  logic [STS_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]         reg_rdata,
    output logic                      irq
);
    localparam int AW     = $clog2(DEPTH);
    localparam int PAIR_W = 2 * COORD_W;
    localparam int AXES   = 2;

    logic [CODE_W-1:0]             code_eff;
    logic [AXES-1:0][COORD_W-1:0]  axis_in;
    logic [AXES-1:0][COORD_W-1:0]  axis_avg;
    logic [AXES-1:0]               axis_push;
    logic                          pair_push;
    coord_pair_t                   pair_in;
    coord_pair_t                   pair_out;
    logic [AW:0]                   fifo_count;
    logic                          fifo_empty;
    logic                          fifo_drop;
    logic                          data_pop;
    logic                          level_hit;
    logic [STS_W-1:0]              status;
    logic [STS_W-1:0]              mask;
    reg_sel_e                      sel;

    always_comb begin
        code_eff   = clamp_code(avg_code);
        axis_in[0] = smp_x;
        axis_in[1] = smp_y;
        pair_push  = &axis_push;
        pair_in.x  = axis_avg[0];
        pair_in.y  = axis_avg[1];
        sel        = reg_sel_e'(reg_addr);
        data_pop   = reg_rd && (sel == SEL_DATA);
        level_hit  = fifo_count >= {1'b0, fifo_thresh};
    end

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        axis_averager #(
            .COORD_W(COORD_W),
            .ACC_W  (ACC_W),
            .CODE_W (CODE_W)
        ) u_avg (
            .clk   (clk),
            .rst   (rst),
            .valid (smp_valid),
            .sample(axis_in[g]),
            .code  (code_eff),
            .push  (axis_push[g]),
            .avg   (axis_avg[g])
        );
    end

    pair_fifo #(
        .DEPTH (DEPTH),
        .DATA_W(PAIR_W)
    ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (pair_push),
        .pop  (data_pop),
        .din  (pair_in),
        .dout (pair_out),
        .count(fifo_count),
        .empty(fifo_empty),
        .drop (fifo_drop)
    );

    irq_status u_irq (
        .clk      (clk),
        .rst      (rst),
        .pen_evt  (pen_evt),
        .level_hit(level_hit),
        .drop     (fifo_drop),
        .wr_status(reg_wr && (sel == SEL_STATUS)),
        .wr_mask  (reg_wr && (sel == SEL_MASK)),
        .wdata    (reg_wdata),
        .status   (status),
        .mask     (mask),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_DATA:   reg_rdata <= fifo_empty ? EMPTY_WORD : pack_word(pair_out);
                SEL_STATUS: reg_rdata <= {{(WORD_W-STS_W){1'b0}}, status};
                SEL_MASK:   reg_rdata <= {{(WORD_W-STS_W){1'b0}}, mask};
                default:    reg_rdata <= '0;
            endcase
        end
    end

    AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (rst)
        (data_pop && fifo_empty) |=> (reg_rdata == EMPTY_WORD)); // R4
    AST_WORD_PAD: assert property (@(posedge clk) disable iff (rst)
        (data_pop && !fifo_empty) |=> (reg_rdata[19:16] == 4'b0) && (reg_rdata[3:0] == 4'b0)); // R3

endmodule

// File: tb/coord_avg_fifo_test.sv
module coord_avg_fifo_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_x = '0;
    logic [11:0] smp_y = '0;
    logic [3:0]  avg_code = 4'd0;
    logic [4:0]  fifo_thresh = 5'd31;
    logic        pen_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [3:0]  reg_wdata = 4'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    coord_avg_fifo uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
        .avg_code(avg_code), .fifo_thresh(fifo_thresh), .pen_evt(pen_evt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] word(input logic [11:0] x, input logic [11:0] y);
        return {y, 4'h0, x, 4'h0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [11:0] x, input logic [11:0] y);
        smp_valid = 1'b1; smp_x = x; smp_y = y;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk(irq == 1'b0, "R10 irq", {31'b0, irq}, 0);
        chk(reg_rdata == 32'h0, "R10 rdata", reg_rdata, 0);
        rd(2'd1, v); chk(v == 32'h0, "R10 status", v, 0);
        rd(2'd2, v); chk(v == 32'h0, "R10 mask", v, 0);
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R10 fifo empty", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_format;
        logic [31:0] v;
        avg_code = 4'd0;
        send(12'h123, 12'hABC);
        rd(2'd0, v); chk(v == word(12'h123, 12'hABC), "R3 packing", v, word(12'h123, 12'hABC));
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R4 empty after drain", v, 32'hFFFF_FFFF);
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R4 repeated empty read", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_avg4;
        logic [31:0] v;
        avg_code = 4'd2;
        for (int i = 0; i < 3; i++) send(12'(10 + i), 12'(4000 + i));
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R1 no push before window end", v, 32'hFFFF_FFFF);
        send(12'd13, 12'd4003);
        rd(2'd0, v); chk(v == word(12'd11, 12'd4001), "R1 mean of 4", v, word(12'd11, 12'd4001));
    endtask

    task automatic t_restart;
        logic [31:0] v;
        avg_code = 4'd1;
        send(12'd10, 12'd20); send(12'd30, 12'd40);
        send(12'd1, 12'd2);   send(12'd2, 12'd3);
        rd(2'd0, v); chk(v == word(12'd20, 12'd30), "R11 first window", v, word(12'd20, 12'd30));
        rd(2'd0, v); chk(v == word(12'd1, 12'd2), "R11 second window", v, word(12'd1, 12'd2));
    endtask

    task automatic t_clamp;
        logic [31:0] v;
        avg_code = 4'd15;
        for (int i = 0; i < 255; i++) send(12'hFFF, 12'(i));
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R2 no push at 255 samples", v, 32'hFFFF_FFFF);
        send(12'hFFF, 12'd255);
        rd(2'd0, v); chk(v == word(12'hFFF, 12'd127), "R2 code 15 acts as 8", v, word(12'hFFF, 12'd127));
        avg_code = 4'd0;
    endtask

    task automatic t_pen;
        logic [31:0] v;
        wr(2'd2, 4'h0);
        pen_evt = 1'b1; @(negedge clk); pen_evt = 1'b0;
        idle(1);
        rd(2'd1, v); chk(v[0] == 1'b1, "R8 pen sets bit0", v, 32'h1);
        idle(2); chk(irq == 1'b0, "R9 masked pen no irq", {31'b0, irq}, 0);
        wr(2'd2, 4'hF);
        rd(2'd2, v); chk(v == 32'h5, "R9 mask writable bits", v, 32'h5);
        idle(2); chk(irq == 1'b1, "R9 unmasked pen irq", {31'b0, irq}, 1);
        pen_evt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 4'h1;
        @(negedge clk);
        pen_evt = 1'b0; reg_wr = 1'b0;
        rd(2'd1, v); chk(v[0] == 1'b1, "R8 set wins over clear", v, 32'h1);
        wr(2'd1, 4'h1);
        rd(2'd1, v); chk(v[0] == 1'b0, "R8 w1c clears", v, 32'h0);
        idle(2); chk(irq == 1'b0, "R9 irq drops", {31'b0, irq}, 0);
        wr(2'd2, 4'h0);
    endtask

    task automatic t_thresh;
        logic [31:0] v;
        fifo_thresh = 5'd3;
        wr(2'd1, 4'hF);
        wr(2'd2, 4'h4);
        send(12'd1, 12'd1); send(12'd2, 12'd2);
        idle(2);
        rd(2'd1, v); chk(v[2] == 1'b0, "R7 below threshold", v, 32'h0);
        chk(irq == 1'b0, "R9 no irq below threshold", {31'b0, irq}, 0);
        send(12'd3, 12'd3);
        idle(3);
        rd(2'd1, v); chk(v[2] == 1'b1, "R7 at threshold", v, 32'h4);
        chk(irq == 1'b1, "R9 fifo irq", {31'b0, irq}, 1);
        wr(2'd1, 4'h4);
        rd(2'd1, v); chk(v[2] == 1'b1, "R7 reasserts after clear", v, 32'h4);
        rd(2'd0, v); chk(v == word(12'd1, 12'd1), "R1 fifo order", v, word(12'd1, 12'd1));
        idle(1);
        rd(2'd1, v); chk(v[2] == 1'b1, "R7 sticky below threshold", v, 32'h4);
        wr(2'd1, 4'h4);
        rd(2'd1, v); chk(v[2] == 1'b0, "R7 clear below threshold", v, 32'h0);
        idle(2); chk(irq == 1'b0, "R9 irq released", {31'b0, irq}, 0);
        rd(2'd0, v); rd(2'd0, v);
        wr(2'd2, 4'h0);
        fifo_thresh = 5'd31;
        idle(2);
        wr(2'd1, 4'hF);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        avg_code = 4'd0;
        for (int i = 0; i < 33; i++) send(12'(i), 12'(i + 100));
        idle(1);
        rd(2'd1, v); chk(v[3] == 1'b1, "R5 overflow flag", v, 32'hC);
        for (int i = 0; i < 32; i++) begin
            rd(2'd0, v); chk(v == word(12'(i), 12'(i + 100)), "R5 kept entry", v, word(12'(i), 12'(i + 100)));
        end
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R5 33rd pair dropped", v, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v[3] == 1'b1, "R5 overflow sticky", v, 32'h8);
        wr(2'd1, 4'hF);
        rd(2'd1, v); chk(v[3] == 1'b0, "R5 overflow cleared", v, 32'h0);
        for (int i = 0; i < 32; i++) send(12'(i), 12'd7);
        smp_valid = 1'b1; smp_x = 12'h7AA; smp_y = 12'h155;
        reg_rd = 1'b1; reg_addr = 2'd0;
        @(negedge clk);
        smp_valid = 1'b0; reg_rd = 1'b0;
        v = reg_rdata;
        chk(v == word(12'd0, 12'd7), "R6 pop during full push", v, word(12'd0, 12'd7));
        idle(1);
        rd(2'd1, v); chk(v[3] == 1'b0, "R6 no overflow on swap", v, 32'h0);
        for (int i = 1; i < 32; i++) begin
            rd(2'd0, v); chk(v == word(12'(i), 12'd7), "R6 remaining entry", v, word(12'(i), 12'd7));
        end
        rd(2'd0, v); chk(v == word(12'h7AA, 12'h155), "R6 swapped-in entry", v, word(12'h7AA, 12'h155));
        rd(2'd0, v); chk(v == 32'hFFFF_FFFF, "R4 empty at end", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset;
        t_format;
        t_avg4;
        t_restart;
        t_clamp;
        t_pen;
        t_thresh;
        t_overflow;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule